// File: doc/BRIEF.md
# Serial Peripheral Master with Converter Sequencing

This block is a serial peripheral master that serves one board with three devices on a shared clock and data-out line: a digital-to-analog converter, an amplifier gain register and a dual-channel analog-to-digital converter. A host writes a clock divider and a 14-bit control word over a single 24-bit data input, using one strobe for each register. Each control word selects the frame length, the bit order, whether the transmit and receive paths are enabled, whether a write, a sample or both run, and whether the next data word is the transmit word.

A write shifts the transmit word out under one of two active-low chip selects. The host picks the target with a select input. A sample pulses a conversion output for one clock, then clocks in two 14-bit results and presents them with a one-cycle valid strobe. A write and a sample can share one operation. The busy flag `go` rises when an operation starts and clears by itself when it ends, so the host can poll it.

Top module: `spi_seq_master`

## Requirements
- R1: While reset is held and just after it: `go`=0, `cs_n`=2'b11, `sclk`=0, `mosi`=0, `conv`=0, `chan_valid`=0, and `chan_a`=`chan_b`=0.
- R2: The control word takes these bits of `data_in`: 13 transmit-capture, 12 sample, 11 LSB-first, 10 transmit enable, 9 receive enable, 8 start, 7 write, 6:0 length. A `load_ctrl` pulse with bit 8 and bit 7 set, while idle, starts a write. `go` is high from the next cycle until the last falling serial clock edge, then returns to 0 by itself.
- R3: With `dac_sel`=1 (sampled at start) a write drives `cs_n[0]` low. With `dac_sel`=0 it drives `cs_n[1]` low. The two selects are never low together, and each is low for exactly the write's bits.
- R4: The length field gives the number of write bits (1 to 24). A value of 0 or above 24 gives 24 bits.
- R5: With bit 11 = 0 the write sends bit length-1 of the transmit word first and bit 0 last. With bit 11 = 1 it sends bit 0 first.
- R6: After a control word with bit 13 set, the first following idle cycle with `load_ctrl` low captures `data_in` as the transmit word. Later words are not captured.
- R7: The serial clock idles low and toggles every max(D,1) system clocks, where D is the divider loaded from `data_in[15:0]` by `load_div`. A write of N bits keeps `go` high for 2·max(D,1)·N cycles. `mosi` changes only when `sclk` falls.
- R8: A sample (bit 12 and bit 8) pulses `conv` for one cycle, then runs 28 serial clocks. `miso` is sampled at each rising edge, MSB first. The first 14 bits go to `chan_a` and the next 14 to `chan_b`, and `chan_valid` pulses for one cycle as `go` clears. `go` is high for 2·max(D,1)·28+1 cycles.
- R9: Bits 12, 8 and 7 together run one operation: a single conversion pulse, the write in the first write-length serial clocks under its chip select, and the 28-bit sample in the same clock train.
- R10: With bit 9 = 0 a sample leaves `chan_a`/`chan_b` unchanged and gives no `chan_valid`. With bit 10 = 0 a write still clocks and selects but keeps `mosi` at 0.
- R11: `load_ctrl` and `load_div` while `go` is high are ignored. A start bit with neither the write nor the sample bit set does not raise `go`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| data_in | input | 24 | Shared control, divider and transmit data |
| load_ctrl | input | 1 | Loads the control word |
| load_div | input | 1 | Loads the clock divider |
| dac_sel | input | 1 | Write target: 1 converter select, 0 amplifier select |
| go | output | 1 | Busy flag, clears itself at the end of an operation |
| conv | output | 1 | Conversion start pulse to the sampling converter |
| cs_n | output | 2 | Active-low chip selects: [0] converter, [1] amplifier |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in from the sampling converter |
| chan_a | output | 14 | First channel result |
| chan_b | output | 14 | Second channel result |
| chan_valid | output | 1 | One-cycle strobe when both results update |

## Verification
A combined control word puts the end of a write (its chip select rising in mid-train) and the clocking of the sample in the same serial clock train. The same word makes the last sample bit, the result update and the clearing of `go` land on one cycle. The bench provokes this with write and sample bits set together. It pushes both the expected write frame and the expected channel pair into its scoreboard. It judges the run by the frame that the chip-select monitor collects, by the pair that comes with the valid strobe, and by the length of the busy window, which must match a sample alone and not a write. The busy-window length check also covers host loads issued in the middle of an operation, which must not stretch it or start a second one.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
  localparam int CTRL_W = 14;
  localparam int LEN_W  = 7;
  // control word bit positions
  localparam int B_TXC = 13;
  localparam int B_SMP = 12;
  localparam int B_LSB = 11;
  localparam int B_TXE = 10;
  localparam int B_RXE = 9;
  localparam int B_GO  = 8;
  localparam int B_WR  = 7;

  typedef struct packed {
    logic             smp;
    logic             lsb;
    logic             txe;
    logic             rxe;
    logic             wr;
    logic [LEN_W-1:0] len;
  } xfer_cfg_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CONV  = 2'd1,
    ST_SHIFT = 2'd2
  } seq_st_t;
endpackage

// File: rtl/spi_seq_regs.sv
module spi_seq_regs
  import spi_seq_pkg::*;
#(
  parameter int TX_W  = 24,
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TX_W-1:0]  data_in,
  input  logic             load_ctrl,
  input  logic             load_div,
  input  logic             busy,
  output xfer_cfg_t        cfg_q,
  output logic [DIV_W-1:0] div_q,
  output logic [TX_W-1:0]  tx_q
);
  xfer_cfg_t        cfg_d;
  logic [DIV_W-1:0] div_d;
  logic [TX_W-1:0]  tx_d;
  logic             arm_q, arm_d;

  always_comb begin
    cfg_d = cfg_q;
    div_d = div_q;
    tx_d  = tx_q;
    arm_d = arm_q;
    if (load_ctrl && !busy) begin
      cfg_d.smp = data_in[B_SMP];
      cfg_d.lsb = data_in[B_LSB];
      cfg_d.txe = data_in[B_TXE];
      cfg_d.rxe = data_in[B_RXE];
      cfg_d.wr  = data_in[B_WR];
      cfg_d.len = data_in[LEN_W-1:0];
      arm_d     = data_in[B_TXC];
    end else if (arm_q && !busy) begin
      tx_d  = data_in;
      arm_d = 1'b0;
    end
    if (load_div && !busy) div_d = data_in[DIV_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      div_q <= '0;
      tx_q  <= '0;
      arm_q <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
      div_q <= div_d;
      tx_q  <= tx_d;
      arm_q <= arm_d;
    end
  end

  // R11: host loads during an operation leave the registers untouched
  a_r11_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && load_ctrl) |=> $stable(cfg_q));
  a_r11_div_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && load_div) |=> $stable(div_q));
  // R6: the transmit word only moves while idle
  a_r6_tx_idle_only: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(tx_q));
endmodule

// File: rtl/spi_seq_clkdiv.sv
module spi_seq_clkdiv #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d, lim;

  always_comb begin
    lim   = (div == '0) ? '0 : div - 1'b1;
    tick  = en && (cnt_q == lim);
    cnt_d = (!en || tick) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R7: the half-period counter never runs past its limit
  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt_q <= lim));
endmodule

// File: rtl/spi_seq_engine.sv
module spi_seq_engine
  import spi_seq_pkg::*;
#(
  parameter int TX_W = 24,
  parameter int CH_W = 14,
  localparam int ADC_BITS = 2 * CH_W,
  localparam int MAX_BITS = (ADC_BITS > TX_W) ? ADC_BITS : TX_W,
  localparam int CNT_W    = $clog2(MAX_BITS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            start_smp,
  input  xfer_cfg_t       cfg,
  input  logic            sel_in,
  input  logic [TX_W-1:0] tx_word,
  input  logic            tick,
  input  logic            miso,
  output logic            go,
  output logic            shift_en,
  output logic            conv,
  output logic            sclk,
  output logic            mosi,
  output logic [1:0]      cs_n,
  output logic [CH_W-1:0] chan_a,
  output logic [CH_W-1:0] chan_b,
  output logic            chan_valid
);
  seq_st_t             st_q, st_d;
  logic                sclk_q, sclk_d;
  logic                sel_q, sel_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [TX_W-1:0]     sr_q, sr_d;
  logic [ADC_BITS-1:0] rx_q, rx_d;
  logic [CH_W-1:0]     cha_q, cha_d, chb_q, chb_d;
  logic                vld_q, vld_d;
  logic [CNT_W-1:0]    wr_bits, total_bits;
  logic                act;

  always_comb begin
    if (cfg.len == '0 || int'(cfg.len) > TX_W) wr_bits = CNT_W'(TX_W);
    else                                        wr_bits = CNT_W'(cfg.len);
    if (cfg.smp && (!cfg.wr || wr_bits < CNT_W'(ADC_BITS))) total_bits = CNT_W'(ADC_BITS);
    else                                                    total_bits = wr_bits;
  end

  always_comb begin
    st_d   = st_q;
    sclk_d = sclk_q;
    sel_d  = sel_q;
    cnt_d  = cnt_q;
    sr_d   = sr_q;
    rx_d   = rx_q;
    cha_d  = cha_q;
    chb_d  = chb_q;
    vld_d  = 1'b0;
    case (st_q)
      ST_IDLE: if (start) begin
        st_d   = start_smp ? ST_CONV : ST_SHIFT;
        sr_d   = tx_word;
        sel_d  = sel_in;
        cnt_d  = '0;
        sclk_d = 1'b0;
        rx_d   = '0;
      end
      ST_CONV: st_d = ST_SHIFT;
      ST_SHIFT: if (tick) begin
        if (!sclk_q) begin
          sclk_d = 1'b1;
          if (cfg.smp) rx_d = {rx_q[ADC_BITS-2:0], miso};
        end else begin
          sclk_d = 1'b0;
          cnt_d  = cnt_q + 1'b1;
          sr_d   = cfg.lsb ? (sr_q >> 1) : (sr_q << 1);
          if (cnt_q + 1'b1 == total_bits) begin
            st_d = ST_IDLE;
            if (cfg.smp && cfg.rxe) begin
              cha_d = rx_q[ADC_BITS-1:CH_W];
              chb_d = rx_q[CH_W-1:0];
              vld_d = 1'b1;
            end
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      sclk_q <= 1'b0;
      sel_q  <= 1'b0;
      cnt_q  <= '0;
      sr_q   <= '0;
      rx_q   <= '0;
      cha_q  <= '0;
      chb_q  <= '0;
      vld_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      sclk_q <= sclk_d;
      sel_q  <= sel_d;
      cnt_q  <= cnt_d;
      sr_q   <= sr_d;
      rx_q   <= rx_d;
      cha_q  <= cha_d;
      chb_q  <= chb_d;
      vld_q  <= vld_d;
    end
  end

  assign go         = (st_q != ST_IDLE);
  assign shift_en   = (st_q == ST_SHIFT);
  assign conv       = (st_q == ST_CONV);
  assign act        = shift_en && cfg.wr && (cnt_q < wr_bits);
  assign mosi       = act && cfg.txe && (cfg.lsb ? sr_q[0] : sr_q[wr_bits - 1'b1]);
  assign cs_n       = {~(act & ~sel_q), ~(act & sel_q)};
  assign sclk       = sclk_q;
  assign chan_a     = cha_q;
  assign chan_b     = chb_q;
  assign chan_valid = vld_q;

  // R3: at most one chip select low
  a_r3_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
  // R7: serial clock idles low
  a_r7_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !go |-> !sclk);
  // R7: data out holds while the serial clock stays high
  a_r7_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));
  // R8: conversion pulse lasts one cycle
  a_r8_conv_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    conv |=> !conv);
  // R8: results appear as the busy flag clears
  a_r8_valid_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    chan_valid |-> (!go && $past(go)));
endmodule

// File: rtl/spi_seq_master.sv
module spi_seq_master
  import spi_seq_pkg::*;
#(
  parameter int TX_W  = 24,
  parameter int DIV_W = 16,
  parameter int CH_W  = 14
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TX_W-1:0] data_in,
  input  logic            load_ctrl,
  input  logic            load_div,
  input  logic            dac_sel,
  output logic            go,
  output logic            conv,
  output logic [1:0]      cs_n,
  output logic            sclk,
  output logic            mosi,
  input  logic            miso,
  output logic [CH_W-1:0] chan_a,
  output logic [CH_W-1:0] chan_b,
  output logic            chan_valid
);
  logic [1:0]       rst_sync_q;
  logic             rst_i_n;
  xfer_cfg_t        cfg_q;
  logic [DIV_W-1:0] div_q;
  logic [TX_W-1:0]  tx_q;
  logic             start, tick, shift_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  assign start = load_ctrl && !go && data_in[B_GO] && (data_in[B_WR] || data_in[B_SMP]);

  spi_seq_regs #(.TX_W(TX_W), .DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(rst_i_n), .data_in(data_in), .load_ctrl(load_ctrl),
    .load_div(load_div), .busy(go), .cfg_q(cfg_q), .div_q(div_q), .tx_q(tx_q)
  );

  spi_seq_clkdiv #(.DIV_W(DIV_W)) u_clkdiv (
    .clk(clk), .rst_n(rst_i_n), .en(shift_en), .div(div_q), .tick(tick)
  );

  spi_seq_engine #(.TX_W(TX_W), .CH_W(CH_W)) u_engine (
    .clk(clk), .rst_n(rst_i_n), .start(start), .start_smp(data_in[B_SMP]),
    .cfg(cfg_q), .sel_in(dac_sel), .tx_word(tx_q), .tick(tick), .miso(miso),
    .go(go), .shift_en(shift_en), .conv(conv), .sclk(sclk), .mosi(mosi),
    .cs_n(cs_n), .chan_a(chan_a), .chan_b(chan_b), .chan_valid(chan_valid)
  );

  // R11: a start word without write or sample leaves the block idle
  a_r11_no_empty_start: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!go && load_ctrl && !data_in[B_WR] && !data_in[B_SMP]) |=> !go);
endmodule

// File: tb/spi_seq_master_bench.sv
`timescale 1ns/1ps
module spi_seq_master_bench;
  logic        clk, rst_n;
  logic [23:0] data_in;
  logic        load_ctrl, load_div, dac_sel, miso;
  logic        go, conv, sclk, mosi, chan_valid;
  logic [1:0]  cs_n;
  logic [13:0] chan_a, chan_b;

  int n_chk = 0, n_fail = 0;
  int vcnt = 0, ccnt = 0;
  logic [33:0] exp_tx[$];
  string       exp_tag[$];
  logic [27:0] exp_ch[$];
  logic [27:0] pat_q[$];

  spi_seq_master u_spi_seq_master (
    .clk(clk), .rst_n(rst_n), .data_in(data_in), .load_ctrl(load_ctrl),
    .load_div(load_div), .dac_sel(dac_sel), .go(go), .conv(conv), .cs_n(cs_n),
    .sclk(sclk), .mosi(mosi), .miso(miso), .chan_a(chan_a), .chan_b(chan_b),
    .chan_valid(chan_valid)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] mk(bit txc, bit smp, bit lsb, bit txe, bit rxe, bit g, bit wr, int len);
    return {10'd0, txc, smp, lsb, txe, rxe, g, wr, 7'(len)};
  endfunction

  function automatic logic [23:0] rev24(input logic [23:0] v);
    logic [23:0] r;
    for (int i = 0; i < 24; i++) r[i] = v[23-i];
    return r;
  endfunction

  task automatic exp_frame(input logic [1:0] tgt, input int n, input logic [23:0] v, input string tag);
    exp_tx.push_back({tgt, 8'(n), v});
    exp_tag.push_back(tag);
  endtask

  task automatic exp_sample(input logic [27:0] p, input bit valid);
    pat_q.push_back(p);
    if (valid) exp_ch.push_back(p);
  endtask

  task automatic set_div(input logic [23:0] d);
    @(negedge clk); data_in = d; load_div = 1'b1;
    @(negedge clk); load_div = 1'b0; data_in = '0;
  endtask

  task automatic set_tx(input logic [23:0] w);
    @(negedge clk); data_in = mk(1,0,0,0,0,0,0,0); load_ctrl = 1'b1;
    @(negedge clk); load_ctrl = 1'b0; data_in = w;
    @(negedge clk); data_in = '0;
  endtask

  // issue a control word, then count busy cycles; poke>0 injects loads mid-run
  task automatic run(input logic [23:0] w, input bit sel, input int exp_n, input string tag, input int poke);
    int n;
    @(negedge clk); data_in = w; dac_sel = sel; load_ctrl = 1'b1;
    @(negedge clk); load_ctrl = 1'b0; data_in = '0;
    n = 0;
    while (go) begin
      n++;
      if (n == poke) begin
        data_in = 24'h001318; load_ctrl = 1'b1; load_div = 1'b1;
      end else if (n == poke + 1) begin
        data_in = '0; load_ctrl = 1'b0; load_div = 1'b0;
      end
      @(negedge clk);
    end
    load_ctrl = 1'b0; load_div = 1'b0;
    chk(n == exp_n, {tag, " busy cycles"}, n, exp_n);
  endtask

  // scoreboard monitor: frames per chip select, results per valid strobe
  initial begin
    bit in_frame = 0; bit p_sclk = 0;
    logic [1:0] tgt = 2'b11; int nb = 0; logic [23:0] acc = '0;
    logic [33:0] e; string t; logic [27:0] c;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (cs_n != 2'b11) begin
          if (!in_frame) begin in_frame = 1; tgt = cs_n; nb = 0; acc = '0; end
          if (sclk && !p_sclk) begin acc = {acc[22:0], mosi}; nb++; end
        end else if (in_frame) begin
          in_frame = 0;
          if (exp_tx.size() == 0) chk(0, "R3 unexpected frame", {30'd0, tgt}, 32'h3);
          else begin
            e = exp_tx.pop_front(); t = exp_tag.pop_front();
            chk(tgt == e[33:32], {t, " select"}, {30'd0, tgt}, {30'd0, e[33:32]});
            chk(nb == int'(e[31:24]), {t, " bit count"}, nb, {24'd0, e[31:24]});
            chk(acc == e[23:0], {t, " data"}, {8'd0, acc}, {8'd0, e[23:0]});
          end
        end
        if (conv) ccnt++;
        if (chan_valid) begin
          vcnt++;
          if (exp_ch.size() == 0) chk(0, "R10 unexpected valid", 1, 0);
          else begin
            c = exp_ch.pop_front();
            chk(chan_a == c[27:14], "R8 chan_a", {18'd0, chan_a}, {18'd0, c[27:14]});
            chk(chan_b == c[13:0], "R8 chan_b", {18'd0, chan_b}, {18'd0, c[13:0]});
          end
        end
      end
      p_sclk = sclk;
    end
  end

  // sampling converter model: MSB first, next bit after each falling edge
  initial begin
    bit on = 0; bit p_s = 0; int idx = 0; logic [27:0] cur = '0;
    miso = 1'b0;
    forever begin
      @(negedge clk);
      if (conv) begin
        if (pat_q.size() > 0) cur = pat_q.pop_front();
        idx = 27; miso = cur[27]; on = 1;
      end else if (on && p_s && !sclk) begin
        if (idx == 0) begin on = 0; miso = 1'b0; end
        else begin idx--; miso = cur[idx]; end
      end
      p_s = sclk;
    end
  end

  task automatic sequence_all();
    int v0, c0;
    logic [13:0] hold_a;
    rst_n = 1'b0; data_in = '0; load_ctrl = 0; load_div = 0; dac_sel = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(go == 0, "R1 go", go, 0);
    chk(cs_n == 2'b11, "R1 cs_n", cs_n, 3);
    chk(sclk == 0 && mosi == 0 && conv == 0, "R1 sclk/mosi/conv", {sclk, mosi, conv}, 0);
    chk(chan_valid == 0 && chan_a == 0 && chan_b == 0, "R1 results", {chan_a, chan_b}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(go == 0 && cs_n == 2'b11, "R1 after release", {go, cs_n}, 3);

    set_div(24'd2);
    // R2/R3 converter write, MSB first, 24 bits
    set_tx(24'h30ABC0); exp_frame(2'b10, 24, 24'h30ABC0, "R2");
    run(mk(0,0,0,1,1,1,1,24), 1, 96, "R2", 0);
    // R3/R4 amplifier write, 8 bits
    set_tx(24'h000011); exp_frame(2'b01, 8, 24'h000011, "R3");
    run(mk(0,0,0,1,1,1,1,8), 0, 32, "R4", 0);
    // R5 LSB first
    set_tx(24'h30ABC0); exp_frame(2'b10, 24, rev24(24'h30ABC0), "R5");
    run(mk(0,0,1,1,1,1,1,24), 1, 96, "R5", 0);
    // R4 length 0 and length 100 both give 24
    set_tx(24'h123456); exp_frame(2'b01, 24, 24'h123456, "R4 len0");
    run(mk(0,0,0,1,1,1,1,0), 0, 96, "R4 len0", 0);
    exp_frame(2'b01, 24, 24'h123456, "R4 len100");
    run(mk(0,0,0,1,1,1,1,100), 0, 96, "R4 len100", 0);
    // R6 only the first word after the capture arm is taken
    set_tx(24'hA5A5A5);
    @(negedge clk); data_in = 24'h5A5A5A;
    @(negedge clk); data_in = '0;
    exp_frame(2'b10, 24, 24'hA5A5A5, "R6");
    run(mk(0,0,0,1,1,1,1,24), 1, 96, "R6", 0);
    // R8 sample only
    c0 = ccnt; v0 = vcnt;
    exp_sample({14'h2345, 14'h1ABC}, 1);
    run(mk(0,1,0,0,1,1,0,24), 0, 113, "R8", 0);
    @(negedge clk);
    chk(ccnt - c0 == 1, "R8 conv width", ccnt - c0, 1);
    chk(vcnt - v0 == 1, "R8 valid count", vcnt - v0, 1);
    // R9 write and sample together
    c0 = ccnt;
    set_tx(24'h305550); exp_frame(2'b10, 24, 24'h305550, "R9");
    exp_sample({14'h0F0F, 14'h3001}, 1);
    run(mk(0,1,0,1,1,1,1,24), 1, 113, "R9", 0);
    @(negedge clk);
    chk(ccnt - c0 == 1, "R9 single conv", ccnt - c0, 1);
    // R10 receive disabled
    v0 = vcnt; hold_a = chan_a;
    exp_sample({14'h1111, 14'h2222}, 0);
    run(mk(0,1,0,0,0,1,0,24), 0, 113, "R10 rx", 0);
    @(negedge clk);
    chk(vcnt == v0, "R10 no valid", vcnt - v0, 0);
    chk(chan_a == hold_a, "R10 chan_a held", {18'd0, chan_a}, {18'd0, hold_a});
    // R10 transmit disabled
    set_tx(24'hFFFFFF); exp_frame(2'b10, 24, 24'h000000, "R10 tx");
    run(mk(0,0,0,0,1,1,1,24), 1, 96, "R10 tx", 0);
    // R11 loads during a run ignored
    c0 = ccnt; v0 = vcnt;
    set_tx(24'h00C3A5); exp_frame(2'b01, 16, 24'h00C3A5, "R11 busy");
    run(mk(0,0,0,1,1,1,1,16), 0, 64, "R11 busy", 5);
    repeat (3) @(negedge clk);
    chk(go == 0 && ccnt == c0 && vcnt == v0, "R11 no restart", {go, 8'(ccnt - c0)}, 0);
    exp_frame(2'b01, 16, 24'h00C3A5, "R11 div kept");
    run(mk(0,0,0,1,1,1,1,16), 0, 64, "R11 div kept", 0);
    // R11 start with neither write nor sample
    @(negedge clk); data_in = mk(0,0,0,1,1,1,0,24); load_ctrl = 1'b1;
    @(negedge clk); load_ctrl = 1'b0; data_in = '0;
    chk(go == 0, "R11 empty start", go, 0);
    // R7 divider 1 and divider 0
    set_div(24'd1);
    exp_frame(2'b01, 8, 24'h0000A5, "R7 div1");
    run(mk(0,0,0,1,1,1,1,8), 0, 16, "R7 div1", 0);
    set_div(24'd0);
    exp_frame(2'b01, 8, 24'h0000A5, "R7 div0");
    run(mk(0,0,0,1,1,1,1,8), 0, 16, "R7 div0", 0);
    repeat (4) @(negedge clk);
    chk(exp_tx.size() == 0, "R3 frames outstanding", exp_tx.size(), 0);
    chk(exp_ch.size() == 0, "R8 results outstanding", exp_ch.size(), 0);
  endtask

  initial begin
    fork
      sequence_all();
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R2 watchdog act=timeout exp=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule